// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit unsigned operands and a carry-in with no clock and no state. The operands are split into four 4-bit groups. Each group forms per-bit generate and propagate terms and hands them to a 4-bit lookahead unit. That unit produces the carries inside the group in sum-of-products form and also produces a group generate and a group propagate. A second-level lookahead unit of the same kind takes the four group pairs and the carry-in, and it returns the carry into each group. No carry ever ripples from bit to bit.

The block also returns the group generate and group propagate for all 16 bits. A wider adder can feed them to a third level of lookahead. The carry-out is formed from that same pair and the carry-in.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + c_in` for every operand pair and carry-in.
- R2: `c_out` equals bit 16 of the 17-bit result of `a_i + b_i + c_in`.
- R3: `grp_prop_o` is 1 exactly when every bit of `a_i XOR b_i` is 1.
- R4: `grp_gen_o` is 1 exactly when `a_i + b_i` with no carry-in reaches 65536 or more, so it does not depend on `c_in`.
- R5: `c_out` equals `grp_gen_o OR (grp_prop_o AND c_in)` for every input.
- R6: When `grp_prop_o` is 1, the carry-in crosses all 16 positions. With `c_in`=0 the result is `sum_o`=0xFFFF and `c_out`=0. With `c_in`=1 the result is `sum_o`=0x0000 and `c_out`=1.
- R7: For 0xFFFF + 0x0001 with `c_in`=0, the outputs are `sum_o`=0x0000, `c_out`=1, `grp_gen_o`=1 and `grp_prop_o`=0.
- R8: The outputs follow an input change within the same time step. No clock edge is needed and no earlier input affects them. With all inputs at zero, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum, modulo 2^16 |
| c_out | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 1 | Generate over all 16 bits |
| grp_prop_o | output | 1 | Propagate over all 16 bits |

## Verification
The bench builds the adder with the package defaults: groups 4 bits wide and four groups, which gives 16 bits. That size puts every group boundary within reach of directed corner patterns. These include operands that set one carry to run across a single boundary and operands that make a carry cross all three. The 33-bit input space is too large to cover in full, so a fixed set of corner operands is crossed with itself under both carry-in values, and about ten thousand random vectors are added. The result, carry-out and both group outputs are checked on every vector.

// File: rtl/cla_pkg.sv
`timescale 1ns/1ps
package cla_pkg;

    // Structure of the adder: groups of GRP_W bits, NUM_GRP groups.
    // The second level reuses the same lookahead unit, so NUM_GRP == GRP_W.
    localparam int GRP_W   = 4;
    localparam int NUM_GRP = 4;
    localparam int DATA_W  = GRP_W * NUM_GRP;

    typedef struct packed {
        logic gen;
        logic prop;
    } pg_t;

    // Bit-level generate / propagate pair.
    function automatic pg_t bit_pg(input logic a, input logic b);
        pg_t r;
        r.gen  = a & b;
        r.prop = a ^ b;
        return r;
    endfunction

endpackage

// File: rtl/cla_lookahead4.sv
`timescale 1ns/1ps
// 4-bit lookahead carry generator: every carry in flat sum-of-products form.
module cla_lookahead4
    import cla_pkg::*;
(
    input  logic [GRP_W-1:0] gen_i,
    input  logic [GRP_W-1:0] prop_i,
    input  logic             c_i,
    output logic [GRP_W-1:0] carry_o,   // carry_o[k] = carry into position k
    output logic             grp_gen_o,
    output logic             grp_prop_o
);

    logic [GRP_W-1:0] g;
    logic [GRP_W-1:0] p;

    assign g = gen_i;
    assign p = prop_i;

    assign carry_o[0] = c_i;
    assign carry_o[1] = g[0]
                      | (p[0] & c_i);
    assign carry_o[2] = g[1]
                      | (p[1] & g[0])
                      | (p[1] & p[0] & c_i);
    assign carry_o[3] = g[2]
                      | (p[2] & g[1])
                      | (p[2] & p[1] & g[0])
                      | (p[2] & p[1] & p[0] & c_i);

    assign grp_gen_o  = g[3]
                      | (p[3] & g[2])
                      | (p[3] & p[2] & g[1])
                      | (p[3] & p[2] & p[1] & g[0]);
    assign grp_prop_o = p[3] & p[2] & p[1] & p[0];

    // The flat carries must agree with the local relation c(k+1) = g(k) | p(k)c(k).
    always_comb begin
        for (int k = 1; k < GRP_W; k++) begin
            assert_carry_chain_R1: assert (carry_o[k] == (g[k-1] | (p[k-1] & carry_o[k-1])))
                else $error("lookahead carry %0d disagrees with local relation", k);
        end
        // Group pair must reproduce the carry out of position 3 (R5).
        assert_group_out_R5: assert ((grp_gen_o | (grp_prop_o & c_i)) == (g[3] | (p[3] & carry_o[3])))
            else $error("group generate/propagate disagree with carry out");
    end

endmodule

// File: rtl/cla_nibble.sv
`timescale 1ns/1ps
// One group: bit cells feeding a lookahead unit, sum from propagate and carry.
module cla_nibble
    import cla_pkg::*;
(
    input  logic [GRP_W-1:0] a_i,
    input  logic [GRP_W-1:0] b_i,
    input  logic             c_i,
    output logic [GRP_W-1:0] sum_o,
    output logic             grp_gen_o,
    output logic             grp_prop_o
);

    pg_t              pg [GRP_W];
    logic [GRP_W-1:0] gen_v;
    logic [GRP_W-1:0] prop_v;
    logic [GRP_W-1:0] carry_v;

    for (genvar i = 0; i < GRP_W; i++) begin : g_bit
        assign pg[i]     = bit_pg(a_i[i], b_i[i]);
        assign gen_v[i]  = pg[i].gen;
        assign prop_v[i] = pg[i].prop;
        assign sum_o[i]  = pg[i].prop ^ carry_v[i];
    end

    cla_lookahead4 u_la (
        .gen_i      (gen_v),
        .prop_i     (prop_v),
        .c_i        (c_i),
        .carry_o    (carry_v),
        .grp_gen_o  (grp_gen_o),
        .grp_prop_o (grp_prop_o)
    );

    always_comb begin
        assert_group_sum_R1: assert ({1'b0, sum_o} ==
                                     (({1'b0, a_i} + {1'b0, b_i} + {{GRP_W{1'b0}}, c_i}) & {1'b0, {GRP_W{1'b1}}}))
            else $error("group sum wrong");
        assert_group_prop_R3: assert (grp_prop_o == (&(a_i ^ b_i)))
            else $error("group propagate wrong");
    end

endmodule

// File: rtl/cla16_adder.sv
`timescale 1ns/1ps
// 16-bit adder: four group units plus one second-level lookahead unit.
module cla16_adder
    import cla_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_in,
    output logic [DATA_W-1:0] sum_o,
    output logic              c_out,
    output logic              grp_gen_o,
    output logic              grp_prop_o
);

    logic [NUM_GRP-1:0] nib_gen;
    logic [NUM_GRP-1:0] nib_prop;
    logic [NUM_GRP-1:0] nib_carry;   // carry into each group

    for (genvar n = 0; n < NUM_GRP; n++) begin : g_grp
        cla_nibble u_nib (
            .a_i        (a_i[n*GRP_W +: GRP_W]),
            .b_i        (b_i[n*GRP_W +: GRP_W]),
            .c_i        (nib_carry[n]),
            .sum_o      (sum_o[n*GRP_W +: GRP_W]),
            .grp_gen_o  (nib_gen[n]),
            .grp_prop_o (nib_prop[n])
        );
    end

    // Second level: same unit, fed with the group pairs.
    cla_lookahead4 u_top_la (
        .gen_i      (nib_gen),
        .prop_i     (nib_prop),
        .c_i        (c_in),
        .carry_o    (nib_carry),
        .grp_gen_o  (grp_gen_o),
        .grp_prop_o (grp_prop_o)
    );

    assign c_out = grp_gen_o | (grp_prop_o & c_in);

    always_comb begin
        assert_full_sum_R1: assert ({c_out, sum_o} ==
                                    ({1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, c_in}))
            else $error("sum or carry-out wrong");
        assert_full_prop_R3: assert (grp_prop_o == (&(a_i ^ b_i)))
            else $error("16-bit propagate wrong");
        assert_full_gen_R4: assert (grp_gen_o == (({1'b0, a_i} + {1'b0, b_i}) >> DATA_W))
            else $error("16-bit generate wrong");
        assert_chain_R6: assert (!grp_prop_o || (sum_o == {DATA_W{~c_in}}))
            else $error("full propagate chain wrong");
    end

endmodule

// File: tb/cla16_adder_tb.sv
`timescale 1ns/1ps
module cla16_adder_tb;

    logic        clk = 1'b0;
    logic [15:0] a, b;
    logic        cin;
    logic [15:0] sum;
    logic        cout, gg, gp;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    cla16_adder u_dut (
        .a_i        (a),
        .b_i        (b),
        .c_in       (cin),
        .sum_o      (sum),
        .c_out      (cout),
        .grp_gen_o  (gg),
        .grp_prop_o (gp)
    );

    // Drive, let settle, compare all four outputs against a reference.
    task automatic check_vec(input logic [15:0] va, input logic [15:0] vb,
                             input logic vc, input string req);
        logic [16:0] full;
        logic [16:0] nocin;
        logic        eg, ep;
        @(negedge clk);
        a = va; b = vb; cin = vc;
        #1;
        full  = {1'b0, va} + {1'b0, vb} + {16'd0, vc};
        nocin = {1'b0, va} + {1'b0, vb};
        eg    = nocin[16];
        ep    = &(va ^ vb);
        vectors++;
        if (sum !== full[15:0] || cout !== full[16] || gg !== eg || gp !== ep) begin
            miscompares++;
            $display("FAIL %s a=%h b=%h cin=%b: actual sum=%h cout=%b gen=%b prop=%b expected sum=%h cout=%b gen=%b prop=%b",
                     req, va, vb, vc, sum, cout, gg, gp, full[15:0], full[16], eg, ep);
        end
    endtask

    task automatic expect_out(input logic [15:0] es, input logic ec, input logic eg,
                              input logic ep, input string req);
        vectors++;
        if (sum !== es || cout !== ec || gg !== eg || gp !== ep) begin
            miscompares++;
            $display("FAIL %s: actual sum=%h cout=%b gen=%b prop=%b expected sum=%h cout=%b gen=%b prop=%b",
                     req, sum, cout, gg, gp, es, ec, eg, ep);
        end
    endtask

    // R8: all-zero inputs give all-zero outputs
    task automatic t_zero_state();
        @(negedge clk);
        a = '0; b = '0; cin = 1'b0;
        #1;
        expect_out(16'h0000, 1'b0, 1'b0, 1'b0, "R8 zero");
    endtask

    // R7: all ones plus one
    task automatic t_ones_plus_one();
        @(negedge clk);
        a = 16'hFFFF; b = 16'h0001; cin = 1'b0;
        #1;
        expect_out(16'h0000, 1'b1, 1'b1, 1'b0, "R7 ffff+1");
        check_vec(16'h0001, 16'hFFFF, 1'b0, "R7 1+ffff");
        check_vec(16'hFFFF, 16'h0000, 1'b1, "R7 ffff+cin");
    endtask

    // R6: full propagate chains, both carry-in values
    task automatic t_prop_chain();
        logic [15:0] pats [4] = '{16'h0000, 16'h5555, 16'h1234, 16'hF0F0};
        foreach (pats[i]) begin
            @(negedge clk);
            a = pats[i]; b = ~pats[i]; cin = 1'b0;
            #1;
            expect_out(16'hFFFF, 1'b0, 1'b0, 1'b1, "R6 chain cin0");
            @(negedge clk);
            cin = 1'b1;
            #1;
            expect_out(16'h0000, 1'b1, 1'b0, 1'b1, "R6 chain cin1");
        end
    endtask

    // R1 R2 R3 R4: corner operands crossed with each other, both carry-ins
    task automatic t_corners();
        logic [15:0] c [12] = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'h7FFF,
                                16'h000F, 16'h00FF, 16'h0FFF, 16'hAAAA, 16'h5555,
                                16'h0F0F, 16'hFFF0};
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                for (int k = 0; k < 2; k++)
                    check_vec(c[i], c[j], k[0], "R1/R2/R3/R4 corner");
    endtask

    // R1 R2 R5: random operands and carry-in
    task automatic t_random();
        for (int i = 0; i < 10000; i++) begin
            check_vec(16'($urandom), 16'($urandom), 1'($urandom), "R1/R2/R5 random");
            if ((cout !== (gg | (gp & cin)))) begin
                miscompares++;
                $display("FAIL R5: actual cout=%b expected %b", cout, gg | (gp & cin));
            end
        end
    endtask

    // R8: outputs follow inputs without any clock edge
    task automatic t_no_clock();
        @(posedge clk);
        #0.5;
        a = 16'h0FFF; b = 16'h0001; cin = 1'b0;
        #1;
        expect_out(16'h1000, 1'b0, 1'b0, 1'b0, "R8 no edge 1");
        a = 16'h00FF; b = 16'h0000; cin = 1'b1;
        #1;
        expect_out(16'h0100, 1'b0, 1'b0, 1'b0, "R8 no edge 2");
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (2) @(posedge clk);
        t_zero_state();
        t_ones_plus_one();
        t_prop_chain();
        t_corners();
        t_no_clock();
        t_random();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule